// File: doc/BRIEF.md
# User Interrupt Vector Mapper

This block sits between sixteen user interrupt request lines and a downstream message engine. Each line has an enable bit and an 8-bit vector number, both set through a small 32-bit register port. A rising edge on a request line marks that line pending. When a pending line is also enabled, the block picks one line, presents its vector number on a valid/ready message port, and pulses that line's acknowledge in the cycle the message is taken.

Software programs the vector map as packed bytes, four lines per 32-bit word. It changes enable bits through separate write-one-to-set and write-one-to-clear offsets, so no read-modify-write is needed. A line that fires while disabled is kept pending and is served once it is enabled. Only one message is outstanding at a time. Among eligible lines the lowest-numbered wins.

Top module: `uim_vector_mapper`

## Requirements
- R1: After a synchronous active-low reset, the enable mask is 0, every vector field reads 0, msg_valid is 0 and irq_ack is all zero.
- R2: Vector fields are 8 bits each, four lines per word, at offsets 0x80 (lines 0-3), 0x84 (lines 4-7), 0x88 (lines 8-11) and 0x8C (lines 12-15). Line 4k+j sits in bits [8j+7:8j] of its word. Each word is written whole and reads back what was written.
- R3: Offset 0x00 reads the enable mask in bits [15:0], with bits [31:16] reading 0. Writing offset 0x04 sets every mask bit whose bit in wdata[15:0] is 1 and leaves the other bits unchanged. wdata[31:16] is ignored. Writes to 0x00 have no effect.
- R4: Writing offset 0x08 clears every mask bit whose bit in wdata[15:0] is 1 and leaves the other bits unchanged.
- R5: A 0-to-1 transition on irq_req[i] marks line i pending whether or not it is enabled. A pending, disabled line stays pending and is issued after it becomes enabled.
- R6: When several enabled lines are pending and no message is outstanding, the lowest-numbered one is issued first.
- R7: At most one message is outstanding. While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and msg_vector stays unchanged.
- R8: msg_vector carries the vector field of the issued line, as it stood in the cycle the line was chosen.
- R9: irq_ack has at most one bit set. The bit for the issued line is 1 only in the cycle where msg_valid and msg_ready are both 1. That cycle clears the line's pending state, and a request held high does not issue again.
- R10: Reads of any other offset, including 0x04, 0x08 and unaligned addresses, return 0. Writes to them change neither the mask nor any vector field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_LINES | User interrupt request lines, edge-detected |
| irq_ack | output | NUM_LINES | Per-line single-cycle acknowledge |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | VEC_W | Vector index of the outstanding message |

## Verification
The bench builds the block with its default parameters: 16 lines, 8-bit vectors, 8-bit byte offsets and a 32-bit data word. With these values all four packed vector words and the full 16-bit mask are reachable. The bench can therefore set distinct vectors on every line and run simultaneous requests on widely separated lines to expose the priority order. It can also stall the message port while a line is disabled or enabled, and hold a request high to show that it issues only once.

// File: rtl/uim_pkg.sv
// Package uim_pkg
// Shared register offsets for the user interrupt vector mapper.
// Assumes byte-addressed, word-aligned register accesses.
package uim_pkg;
    localparam int MASK_RD_OFS   = 'h00;  // enable mask read view
    localparam int MASK_SET_OFS  = 'h04;  // write-one-to-set alias
    localparam int MASK_CLR_OFS  = 'h08;  // write-one-to-clear alias
    localparam int VMAP_BASE_OFS = 'h80;  // first packed vector word
endpackage

// File: rtl/uim_regs.sv
// Module uim_regs
// Holds the enable mask and the per-line vector map, and decodes the
// register port. Writes take effect at the clock edge; reads are
// combinational from the address. Assumes DATA_W is a multiple of VEC_W
// and NUM_LINES a multiple of the lines packed per word.
module uim_regs
    import uim_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int VEC_W     = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_we,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic [NUM_LINES-1:0]       mask_o,
    output logic [NUM_LINES*VEC_W-1:0] vmap_o
);
    localparam int LPW      = DATA_W / VEC_W;
    localparam int VWORDS   = NUM_LINES / LPW;
    localparam int VMAP_END = VMAP_BASE_OFS + 4 * VWORDS;

    logic [NUM_LINES-1:0] mask_q;
    logic [VEC_W-1:0]     vmap_q [NUM_LINES];
    logic                 hit_set, hit_clr, hit_mask, hit_vmap;
    int                   addr_int;
    int                   vword;
    logic [NUM_LINES-1:0] set_bits, clr_bits;

    // Address decode for every register view.
    always_comb begin
        addr_int = int'(reg_addr);
        hit_mask = (addr_int == MASK_RD_OFS);
        hit_set  = (addr_int == MASK_SET_OFS);
        hit_clr  = (addr_int == MASK_CLR_OFS);
        hit_vmap = (addr_int >= VMAP_BASE_OFS) && (addr_int < VMAP_END)
                   && (reg_addr[1:0] == 2'b00);
        vword    = (addr_int - VMAP_BASE_OFS) >>> 2;
        set_bits = (reg_we && hit_set) ? reg_wdata[NUM_LINES-1:0] : '0;
        clr_bits = (reg_we && hit_clr) ? reg_wdata[NUM_LINES-1:0] : '0;
    end

    // Enable mask update through the set and clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q | set_bits) & ~clr_bits;
    end

    // One byte register per line, written from its lane of the word.
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_vmap
        always_ff @(posedge clk) begin
            if (!rst_n)
                vmap_q[l] <= '0;
            else if (reg_we && hit_vmap && (vword == l / LPW))
                vmap_q[l] <= reg_wdata[(l % LPW)*VEC_W +: VEC_W];
        end
        assign vmap_o[l*VEC_W +: VEC_W] = vmap_q[l];
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        if (hit_mask) begin
            reg_rdata[NUM_LINES-1:0] = mask_q;
        end else if (hit_vmap) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                if (vword == l / LPW)
                    reg_rdata[(l % LPW)*VEC_W +: VEC_W] = vmap_q[l];
            end
        end
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/uim_pending.sv
// Module uim_pending
// Detects rising edges on the request lines and keeps one pending bit
// per line until the acknowledge for that line clears it. A new edge in
// the same cycle as the clear wins, so the new request is not lost.
// Assumes request lines are synchronous to clk.
module uim_pending #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic [NUM_LINES-1:0] clr_i,
    output logic [NUM_LINES-1:0] pend_o
);
    logic [NUM_LINES-1:0] req_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] rise;

    // Edge detect against the previous sample.
    always_comb rise = req_i & ~req_q;

    // Previous request sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_i;
    end

    // Pending set on edge, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | rise;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/uim_arbiter.sv
// Module uim_arbiter
// Picks the lowest-numbered line that is both pending and enabled,
// latches its line index and vector, and holds one message on a
// valid/ready port until accepted. The acceptance cycle drives the
// line's acknowledge. A chosen message stays committed even if its
// enable bit is cleared while it waits.
module uim_arbiter #(
    parameter int NUM_LINES = 16,
    parameter int VEC_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LINES-1:0]       pend_i,
    input  logic [NUM_LINES-1:0]       mask_i,
    input  logic [NUM_LINES*VEC_W-1:0] vmap_i,
    input  logic                       msg_ready,
    output logic                       msg_valid,
    output logic [VEC_W-1:0]           msg_vector,
    output logic [NUM_LINES-1:0]       ack_o
);
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [NUM_LINES-1:0] elig;
    logic                 win_found;
    logic [IDX_W-1:0]     win_idx;
    logic                 busy_q;
    logic [IDX_W-1:0]     line_q;
    logic [VEC_W-1:0]     vec_q;

    // Fixed priority select: lowest index wins.
    always_comb begin
        elig      = pend_i & mask_i;
        win_found = 1'b0;
        win_idx   = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_found = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
    end

    // Outstanding message state: grant when idle, retire on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            line_q <= '0;
            vec_q  <= '0;
        end else if (busy_q) begin
            if (msg_ready) busy_q <= 1'b0;
        end else if (win_found) begin
            busy_q <= 1'b1;
            line_q <= win_idx;
            vec_q  <= vmap_i[win_idx*VEC_W +: VEC_W];
        end
    end

    // Acknowledge pulse for the accepted line.
    always_comb begin
        ack_o = '0;
        if (busy_q && msg_ready) ack_o[line_q] = 1'b1;
    end

    assign msg_valid  = busy_q;
    assign msg_vector = vec_q;
endmodule

// File: rtl/uim_vector_mapper.sv
// Module uim_vector_mapper (top)
// User interrupt front end: register-programmed enable mask and vector
// map, per-line pending capture, lowest-index arbitration and a single
// outstanding valid/ready message with per-line acknowledge.
// Assumes all inputs are synchronous to clk.
module uim_vector_mapper #(
    parameter int NUM_LINES = 16,
    parameter int VEC_W     = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req,
    output logic [NUM_LINES-1:0] irq_ack,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [VEC_W-1:0]     msg_vector
);
    logic [NUM_LINES-1:0]       enable_mask;
    logic [NUM_LINES*VEC_W-1:0] vmap_flat;
    logic [NUM_LINES-1:0]       pend;

    uim_regs #(
        .NUM_LINES(NUM_LINES), .VEC_W(VEC_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mask_o(enable_mask), .vmap_o(vmap_flat)
    );

    uim_pending #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .req_i(irq_req), .clr_i(irq_ack), .pend_o(pend)
    );

    uim_arbiter #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .pend_i(pend), .mask_i(enable_mask), .vmap_i(vmap_flat),
        .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_vector(msg_vector), .ack_o(irq_ack)
    );
endmodule

// File: rtl/uim_checker.sv
// Module uim_checker
// Protocol and register properties for uim_vector_mapper, attached by
// bind. Observes ports plus the internal enable mask and pending bits.
module uim_checker
    import uim_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int VEC_W     = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_ack,
    input logic                 msg_valid,
    input logic                 msg_ready,
    input logic [VEC_W-1:0]     msg_vector,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic                 reg_we,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic [NUM_LINES-1:0] enable_mask,
    input logic [NUM_LINES-1:0] pend
);
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack)); // R9
    AST_ACK_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack) |-> (msg_valid && msg_ready)); // R9
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack) |=> (irq_ack == '0)); // R9
    AST_ACK_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack) |-> ((irq_ack & pend) == irq_ack)); // R5
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> msg_valid); // R7
    AST_VECTOR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> $stable(msg_vector)); // R7
    AST_MASK_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && int'(reg_addr) == MASK_SET_OFS) |=>
        ((enable_mask & $past(reg_wdata[NUM_LINES-1:0])) == $past(reg_wdata[NUM_LINES-1:0]))); // R3
    AST_MASK_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && int'(reg_addr) == MASK_CLR_OFS) |=>
        ((enable_mask & $past(reg_wdata[NUM_LINES-1:0])) == '0)); // R4
    AST_MASK_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && (int'(reg_addr) == MASK_SET_OFS || int'(reg_addr) == MASK_CLR_OFS))
        |=> $stable(enable_mask)); // R10
endmodule

bind uim_vector_mapper uim_checker #(
    .NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .enable_mask(enable_mask), .pend(pend)
);

// File: tb/tb_uim_vector_mapper.sv
// Bench for uim_vector_mapper: a behavioural reference model advanced on
// every rising edge and compared against the outputs on every cycle,
// plus directed checks for ordering and single-issue behaviour.
module tb_uim_vector_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_req;
    logic [15:0] irq_ack;
    logic [7:0]  reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        msg_valid;
    logic        msg_ready;
    logic [7:0]  msg_vector;

    int n_checks = 0;
    int n_errors = 0;

    // Reference model state
    bit [15:0] m_mask;
    bit [7:0]  m_vec [16];
    bit [15:0] m_pend;
    bit [15:0] m_prev;
    bit        m_busy;
    int        m_line;
    bit [7:0]  m_cvec;
    bit [15:0] m_rise;
    bit [15:0] m_ackm;

    // Observed acknowledge history
    int ack_order[$];
    int ack_count[16];
    bit model_on = 1'b0;

    uim_vector_mapper dut (
        .clk(clk), .rst_n(rst_n),
        .irq_req(irq_req), .irq_ack(irq_ack),
        .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input int a);
        int w;
        if (a == 'h00) return {16'h0, m_mask};
        if (a >= 'h80 && a < 'h90 && (a % 4) == 0) begin
            w = (a - 'h80) / 4;
            return {m_vec[4*w+3], m_vec[4*w+2], m_vec[4*w+1], m_vec[4*w]};
        end
        return 32'h0;
    endfunction

    // Reference model: advances with the design on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = '0; m_pend = '0; m_prev = '0; m_busy = 1'b0;
            m_line = 0; m_cvec = '0;
            for (int i = 0; i < 16; i++) m_vec[i] = '0;
        end else begin
            m_rise = irq_req & ~m_prev;
            m_ackm = '0;
            if (m_busy) begin
                if (msg_ready) begin
                    m_ackm[m_line] = 1'b1;
                    m_busy = 1'b0;
                end
            end else if ((m_pend & m_mask) != 0) begin
                for (int i = 15; i >= 0; i--)
                    if (m_pend[i] && m_mask[i]) m_line = i;
                m_busy = 1'b1;
                m_cvec = m_vec[m_line];
            end
            m_pend = (m_pend & ~m_ackm) | m_rise;
            m_prev = irq_req;
            if (reg_we) begin
                if (reg_addr == 8'h04) m_mask = m_mask | reg_wdata[15:0];
                else if (reg_addr == 8'h08) m_mask = m_mask & ~reg_wdata[15:0];
                else if (reg_addr >= 8'h80 && reg_addr < 8'h90 && reg_addr[1:0] == 2'b00)
                    for (int b = 0; b < 4; b++)
                        m_vec[(int'(reg_addr) - 'h80) + b] = reg_wdata[8*b +: 8];
            end
        end
    end

    // Cycle comparison, away from the active edge.
    always @(negedge clk) begin
        #2;
        if (rst_n && model_on) begin
            logic [15:0] eack;
            string rtag;
            eack = (m_busy && msg_ready) ? (16'h1 << m_line) : 16'h0;
            check(msg_valid == m_busy, "R7", "msg_valid", 32'(msg_valid), 32'(m_busy));
            if (m_busy)
                check(msg_vector == m_cvec, "R8", "msg_vector", 32'(msg_vector), 32'(m_cvec));
            check(irq_ack == eack, "R9", "irq_ack", 32'(irq_ack), 32'(eack));
            rtag = (reg_addr == 8'h00) ? "R3" : (reg_addr >= 8'h80 && reg_addr < 8'h90) ? "R2" : "R10";
            check(reg_rdata == exp_rdata(int'(reg_addr)), rtag, "reg_rdata",
                  reg_rdata, exp_rdata(int'(reg_addr)));
            for (int i = 0; i < 16; i++)
                if (irq_ack[i]) begin
                    ack_order.push_back(i);
                    ack_count[i]++;
                end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, "directed read", reg_rdata, exp);
    endtask

    task automatic pulse(input logic [15:0] lines);
        @(negedge clk);
        irq_req = irq_req | lines;
        @(negedge clk);
        irq_req = irq_req & ~lines;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_req = '0; reg_addr = 8'h00; reg_we = 1'b0;
        reg_wdata = '0; msg_ready = 1'b1;
        cyc(3);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(msg_valid == 1'b0, "R1", "msg_valid after reset", 32'(msg_valid), 0);
        check(irq_ack == 16'h0, "R1", "irq_ack after reset", 32'(irq_ack), 0);
        check(reg_rdata == 32'h0, "R1", "mask after reset", reg_rdata, 0);
        model_on = 1'b1;
        for (int w = 0; w < 4; w++) rd(8'(8'h80 + 4*w), 32'h0, "R1");

        // R2: program distinct vectors and read them back
        wr(8'h80, 32'h13121110);
        wr(8'h84, 32'h17161514);
        wr(8'h88, 32'h1B1A1918);
        wr(8'h8C, 32'hA3A2A1A0);
        rd(8'h84, 32'h17161514, "R2");
        rd(8'h8C, 32'hA3A2A1A0, "R2");

        // R10: unmapped and unaligned offsets
        wr(8'h0C, 32'hFFFFFFFF);
        wr(8'h90, 32'hFFFFFFFF);
        wr(8'h81, 32'hFFFFFFFF);
        wr(8'h00, 32'h0000FFFF);
        rd(8'h0C, 32'h0, "R10");
        rd(8'h04, 32'h0, "R10");
        rd(8'h00, 32'h0, "R10");
        rd(8'h80, 32'h13121110, "R10");

        // R5: request on a disabled line is held, then issued once enabled
        pulse(16'h0020);
        cyc(6);
        check(msg_valid == 1'b0, "R5", "no issue while disabled", 32'(msg_valid), 0);
        msg_ready = 1'b0;
        wr(8'h04, 32'hFFFF0020);
        rd(8'h00, 32'h00000020, "R3");
        cyc(2);
        check(msg_valid == 1'b1 && msg_vector == 8'h15, "R7", "stalled message held",
              {23'h0, msg_valid, msg_vector}, 32'h115);
        cyc(3);
        msg_ready = 1'b1;
        cyc(2);
        check(ack_count[5] == 1, "R5", "held line issued once", ack_count[5], 1);

        // R6: simultaneous requests served lowest first
        wr(8'h04, 32'h0000FFFF);
        ack_order.delete();
        pulse(16'h1208);
        cyc(10);
        check(ack_order.size() == 3, "R6", "ack count", ack_order.size(), 3);
        if (ack_order.size() == 3) begin
            check(ack_order[0] == 3, "R6", "first served", ack_order[0], 3);
            check(ack_order[1] == 9, "R6", "second served", ack_order[1], 9);
            check(ack_order[2] == 12, "R6", "third served", ack_order[2], 12);
        end

        // R4: clear one bit, others stay; cleared line holds its request
        wr(8'h08, 32'hFFFF0004);
        rd(8'h00, 32'h0000FFFB, "R4");
        ack_count[2] = 0;
        pulse(16'h0004);
        cyc(5);
        check(ack_count[2] == 0, "R4", "cleared line not issued", ack_count[2], 0);
        wr(8'h04, 32'h00000004);
        cyc(4);
        check(ack_count[2] == 1, "R5", "line issued after re-enable", ack_count[2], 1);

        // R9: a level-held request issues only once, with a slow consumer
        ack_count[7] = 0;
        @(negedge clk); irq_req[7] = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); msg_ready = (k % 3 == 2);
        end
        msg_ready = 1'b1;
        cyc(3);
        check(ack_count[7] == 1, "R9", "held level issues once", ack_count[7], 1);
        @(negedge clk); irq_req[7] = 1'b0;

        // R8: vector reprogrammed while waiting uses the value at selection
        msg_ready = 1'b0;
        pulse(16'h8000);
        cyc(2);
        wr(8'h8C, 32'h55A2A1A0);
        cyc(2);
        check(msg_vector == 8'hA3, "R8", "vector latched at selection", 32'(msg_vector), 32'hA3);
        msg_ready = 1'b1;
        cyc(2);
        pulse(16'h8000);
        msg_ready = 1'b0;
        cyc(3);
        check(msg_vector == 8'h55, "R8", "new vector used", 32'(msg_vector), 32'h55);
        msg_ready = 1'b1;
        cyc(4);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule